// File: doc/BRIEF.md
# Windowed Address Decoder with Access Protection

This block maps each bus request to one of eight programmable address windows. A window is set by four values: a base in the upper 16 address bits, a size given as size minus one at 64 KiB granularity, a 4-bit target identifier and an 8-bit attribute. A separate enable word switches windows on and off. Every requesting channel has its own permission word with a two-bit code per window. The code grants no access, read-only access or full access.

A request carries a 32-bit address, a write flag and a channel number. One clock later the block returns the winning window, its target and attribute, and a remap value that extends the address for the low-numbered windows. It also returns one of three error classes: address miss, access-protection violation or write-protect violation. The first faulting address and its class are held in error registers until software clears them through the register port. That port also programs all windows and permissions.

Top module: `addr_window_guard`

## Requirements
- R1: Window w hits when its enable bit is set and `reqAddr[31:16] & ~size[31:16]` equals `base[31:16]`. The size field holds (window bytes / 64 KiB) − 1, so a size field of 0x000F spans 1 MiB.
- R2: A window whose bit in the enable register (bit w for window w) is clear never hits, even when its address fields match.
- R3: When several windows hit, the window with the lowest index is reported.
- R4: The response is registered. `rspValid` is high exactly in the cycle after a cycle with `reqValid` high. In that cycle `rspWin`, `rspTarget` and `rspAttr` show the selected window's index, target (base register bits 3:0) and attribute (base register bits 15:8).
- R5: Windows 0 to NUM_REMAP−1 each own a remap register whose value appears on `rspRemap` when that window is selected. For any other window, and on a miss, `rspRemap` is zero.
- R6: A request that hits no window raises `errMiss`, with `rspHit`, `rspTarget` and `rspAttr` at zero. At most one error output is high in any cycle.
- R7: The channel's permission code for window w sits at bits 2w+1:2w of that channel's permission register. Code 0 (no access) or code 2 (reserved) raises `errAccProt` for reads and writes alike.
- R8: Code 1 (read only) raises `errWrProt` on a write and accepts a read. Code 3 accepts both reads and writes.
- R9: The first erroneous request stores its address in the error-address register and its class in the error-cause register. The cause register bits are: bit 0 miss, bit 1 access-protection, bit 2 write-protect, bit 3 pending. Later errors leave both registers unchanged until software writes the cause register, which clears them. An error arriving in the same cycle as the clear is stored.
- R10: The register word map is: 0–7 base (`{base[15:0], attr[7:0], 4'b0, target[3:0]}`), 8–15 size (`{size[15:0], 16'b0}`), 16–19 remap, 20 enable, 21–24 channel 0–3 permissions, 25 error address, 26 error cause. Reads return the stored values, and every register reads zero after reset.
- R11: In a cycle without `reqValid` the block produces no response, raises no error and captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational from regAddr) |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Request address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqChan | input | 2 | Requesting channel |
| rspValid | output | 1 | Response valid |
| rspHit | output | 1 | A window matched |
| rspWin | output | 3 | Index of selected window |
| rspTarget | output | 4 | Target identifier of selected window |
| rspAttr | output | 8 | Attribute of selected window |
| rspRemap | output | 32 | High-address remap of selected window |
| errMiss | output | 1 | No window matched |
| errAccProt | output | 1 | Access-protection violation |
| errWrProt | output | 1 | Write to read-only window |

## Verification
A corrupted window field or enable bit shows on the next response after any request into that window. It appears as a wrong target, a wrong attribute or a false miss, one cycle after the request. A faulty priority chain or permission index is visible only on overlapping or multi-channel requests, so the stimulus includes both. A broken error-capture state reveals itself only when the error registers are read back. A capture that overwrites a held entry shows on the first read after a second fault. A missed clear shows on the read right after the cause write.

// File: rtl/awg_pkg.sv
package awg_pkg;
  // Strobes from the decision logic to the register datapath.
  typedef struct packed {
    logic capture;
    logic wrProt;
    logic accProt;
    logic miss;
  } errStrobe_t;

  // Two-bit permission codes.
  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_RO   = 2'd1;
  localparam logic [1:0] PERM_RSVD = 2'd2;
  localparam logic [1:0] PERM_FULL = 2'd3;
endpackage

// File: rtl/awg_match.sv
module awg_match #(
  parameter int NUM_WIN = 8
) (
  input  logic [15:0]               addrHi,
  input  logic [NUM_WIN-1:0][15:0]  winBase,
  input  logic [NUM_WIN-1:0][15:0]  winSize,
  input  logic [NUM_WIN-1:0]        winEn,
  output logic [NUM_WIN-1:0]        hitVec
);
  // One comparator per window: size bits act as don't-care mask.
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    assign hitVec[w] = winEn[w] && ((addrHi & ~winSize[w]) == winBase[w]);
  end
endmodule

// File: rtl/awg_regs.sv
module awg_regs
  import awg_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_CHAN  = 4,
  parameter int NUM_REMAP = 4,
  parameter int REG_AW    = 6,
  parameter int BASE_OFS  = 0,
  parameter int SIZE_OFS  = 8,
  parameter int REMAP_OFS = 16,
  parameter int EN_OFS    = 20,
  parameter int PERM_OFS  = 21,
  parameter int ERRA_OFS  = 25,
  parameter int ERRC_OFS  = 26
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              regWr,
  input  logic [REG_AW-1:0]                 regAddr,
  input  logic [31:0]                       regWrData,
  output logic [31:0]                       regRdData,
  input  errStrobe_t                        errStb,
  input  logic [31:0]                       errAddrIn,
  output logic [NUM_WIN-1:0][15:0]          winBase,
  output logic [NUM_WIN-1:0][15:0]          winSize,
  output logic [NUM_WIN-1:0][3:0]           winTgt,
  output logic [NUM_WIN-1:0][7:0]           winAttr,
  output logic [NUM_WIN-1:0]                winEn,
  output logic [NUM_CHAN-1:0][2*NUM_WIN-1:0] chanPerm,
  output logic [NUM_REMAP-1:0][31:0]        remapVal,
  output logic                              errPending,
  output logic [31:0]                       errAddrQ,
  output logic [2:0]                        errCause
);
  localparam int PERM_W = 2 * NUM_WIN;

  logic clrWr;
  assign clrWr = regWr && (regAddr == REG_AW'(ERRC_OFS));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        winBase[w] <= '0;
        winAttr[w] <= '0;
        winTgt[w]  <= '0;
        winSize[w] <= '0;
      end else if (regWr) begin
        if (regAddr == REG_AW'(BASE_OFS + w)) begin
          winBase[w] <= regWrData[31:16];
          winAttr[w] <= regWrData[15:8];
          winTgt[w]  <= regWrData[3:0];
        end
        if (regAddr == REG_AW'(SIZE_OFS + w))
          winSize[w] <= regWrData[31:16];
      end
    end
  end

  for (genvar r = 0; r < NUM_REMAP; r++) begin : g_remap
    always_ff @(posedge clk) begin
      if (!rstN)                                          remapVal[r] <= '0;
      else if (regWr && regAddr == REG_AW'(REMAP_OFS + r)) remapVal[r] <= regWrData;
    end
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN)                                         chanPerm[c] <= '0;
      else if (regWr && regAddr == REG_AW'(PERM_OFS + c)) chanPerm[c] <= regWrData[PERM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                    winEn <= '0;
    else if (regWr && regAddr == REG_AW'(EN_OFS)) winEn <= regWrData[NUM_WIN-1:0];
  end

  // Error capture: first fault is held; a capture beats a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errPending <= 1'b0;
      errAddrQ   <= '0;
      errCause   <= '0;
    end else if (errStb.capture && (!errPending || clrWr)) begin
      errPending <= 1'b1;
      errAddrQ   <= errAddrIn;
      errCause   <= {errStb.wrProt, errStb.accProt, errStb.miss};
    end else if (clrWr) begin
      errPending <= 1'b0;
      errAddrQ   <= '0;
      errCause   <= '0;
    end
  end

  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (regAddr == REG_AW'(BASE_OFS + i))
        regRdData = {winBase[i], winAttr[i], 4'h0, winTgt[i]};
      if (regAddr == REG_AW'(SIZE_OFS + i))
        regRdData = {winSize[i], 16'h0};
    end
    for (int i = 0; i < NUM_REMAP; i++)
      if (regAddr == REG_AW'(REMAP_OFS + i)) regRdData = remapVal[i];
    for (int i = 0; i < NUM_CHAN; i++)
      if (regAddr == REG_AW'(PERM_OFS + i)) regRdData = 32'(chanPerm[i]);
    if (regAddr == REG_AW'(EN_OFS))   regRdData = 32'(winEn);
    if (regAddr == REG_AW'(ERRA_OFS)) regRdData = errAddrQ;
    if (regAddr == REG_AW'(ERRC_OFS)) regRdData = {28'h0, errPending, errCause};
  end
endmodule

// File: rtl/awg_ctrl.sv
module awg_ctrl
  import awg_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_CHAN  = 4,
  parameter int NUM_REMAP = 4,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic                               reqWrite,
  input  logic [CHAN_W-1:0]                  reqChan,
  input  logic [NUM_WIN-1:0]                 hitVec,
  input  logic [NUM_WIN-1:0][3:0]            winTgt,
  input  logic [NUM_WIN-1:0][7:0]            winAttr,
  input  logic [NUM_CHAN-1:0][2*NUM_WIN-1:0] chanPerm,
  input  logic [NUM_REMAP-1:0][31:0]         remapVal,
  output errStrobe_t                         errStb,
  output logic                               rspValid,
  output logic                               rspHit,
  output logic [WIN_W-1:0]                   rspWin,
  output logic [3:0]                         rspTarget,
  output logic [7:0]                         rspAttr,
  output logic [31:0]                        rspRemap,
  output logic                               errMiss,
  output logic                               errAccProt,
  output logic                               errWrProt
);
  logic             anyHit;
  logic [WIN_W-1:0] selWin;
  logic [1:0]       perm;
  logic [31:0]      remapSel;
  logic             missC, accC, wrC;

  // Lowest index wins: scan downward so the last assignment is the smallest.
  always_comb begin
    selWin = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--)
      if (hitVec[i]) selWin = WIN_W'(i);
  end

  assign anyHit = |hitVec;
  assign perm   = chanPerm[reqChan][{selWin, 1'b0} +: 2];

  always_comb begin
    remapSel = '0;
    for (int i = 0; i < NUM_REMAP; i++)
      if (anyHit && selWin == WIN_W'(i)) remapSel = remapVal[i];
  end

  assign missC = !anyHit;
  assign accC  = anyHit && (perm == PERM_NONE || perm == PERM_RSVD);
  assign wrC   = anyHit && (perm == PERM_RO) && reqWrite;

  assign errStb = '{capture: reqValid && (missC || accC || wrC),
                    wrProt:  wrC,
                    accProt: accC,
                    miss:    missC};

  always_ff @(posedge clk) begin
    if (!rstN || !reqValid) begin
      rspValid   <= 1'b0;
      rspHit     <= 1'b0;
      rspWin     <= '0;
      rspTarget  <= '0;
      rspAttr    <= '0;
      rspRemap   <= '0;
      errMiss    <= 1'b0;
      errAccProt <= 1'b0;
      errWrProt  <= 1'b0;
    end else begin
      rspValid   <= 1'b1;
      rspHit     <= anyHit;
      rspWin     <= selWin;
      rspTarget  <= anyHit ? winTgt[selWin]  : 4'h0;
      rspAttr    <= anyHit ? winAttr[selWin] : 8'h0;
      rspRemap   <= remapSel;
      errMiss    <= missC;
      errAccProt <= accC;
      errWrProt  <= wrC;
    end
  end
endmodule

// File: rtl/addr_window_guard.sv
module addr_window_guard
  import awg_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_CHAN  = 4,
  parameter int NUM_REMAP = 4,
  parameter int REG_AW    = 6,
  localparam int WIN_W    = $clog2(NUM_WIN),
  localparam int CHAN_W   = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic [31:0]       reqAddr,
  input  logic              reqWrite,
  input  logic [CHAN_W-1:0] reqChan,
  output logic              rspValid,
  output logic              rspHit,
  output logic [WIN_W-1:0]  rspWin,
  output logic [3:0]        rspTarget,
  output logic [7:0]        rspAttr,
  output logic [31:0]       rspRemap,
  output logic              errMiss,
  output logic              errAccProt,
  output logic              errWrProt
);
  localparam int BASE_OFS  = 0;
  localparam int SIZE_OFS  = BASE_OFS + NUM_WIN;
  localparam int REMAP_OFS = SIZE_OFS + NUM_WIN;
  localparam int EN_OFS    = REMAP_OFS + NUM_REMAP;
  localparam int PERM_OFS  = EN_OFS + 1;
  localparam int ERRA_OFS  = PERM_OFS + NUM_CHAN;
  localparam int ERRC_OFS  = ERRA_OFS + 1;

  logic [NUM_WIN-1:0][15:0]           winBase, winSize;
  logic [NUM_WIN-1:0][3:0]            winTgt;
  logic [NUM_WIN-1:0][7:0]            winAttr;
  logic [NUM_WIN-1:0]                 winEn, hitVec;
  logic [NUM_CHAN-1:0][2*NUM_WIN-1:0] chanPerm;
  logic [NUM_REMAP-1:0][31:0]         remapVal;
  logic                               errPending;
  logic [31:0]                        errAddrQ;
  logic [2:0]                         errCause;
  errStrobe_t                         errStb;

  awg_regs #(
    .NUM_WIN(NUM_WIN), .NUM_CHAN(NUM_CHAN), .NUM_REMAP(NUM_REMAP), .REG_AW(REG_AW),
    .BASE_OFS(BASE_OFS), .SIZE_OFS(SIZE_OFS), .REMAP_OFS(REMAP_OFS), .EN_OFS(EN_OFS),
    .PERM_OFS(PERM_OFS), .ERRA_OFS(ERRA_OFS), .ERRC_OFS(ERRC_OFS)
  ) i_regs (
    .clk, .rstN, .regWr, .regAddr, .regWrData, .regRdData,
    .errStb, .errAddrIn(reqAddr),
    .winBase, .winSize, .winTgt, .winAttr, .winEn, .chanPerm, .remapVal,
    .errPending, .errAddrQ, .errCause
  );

  awg_match #(.NUM_WIN(NUM_WIN)) i_match (
    .addrHi(reqAddr[31:16]), .winBase, .winSize, .winEn, .hitVec
  );

  awg_ctrl #(.NUM_WIN(NUM_WIN), .NUM_CHAN(NUM_CHAN), .NUM_REMAP(NUM_REMAP)) i_ctrl (
    .clk, .rstN, .reqValid, .reqWrite, .reqChan, .hitVec, .winTgt, .winAttr,
    .chanPerm, .remapVal, .errStb, .rspValid, .rspHit, .rspWin, .rspTarget,
    .rspAttr, .rspRemap, .errMiss, .errAccProt, .errWrProt
  );
endmodule

// File: rtl/awg_checker.sv
module awg_checker #(
  parameter int REG_AW   = 6,
  parameter int CLR_ADDR = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              regWr,
  input logic [REG_AW-1:0] regAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic [3:0]        rspTarget,
  input logic              errMiss,
  input logic              errAccProt,
  input logic              errWrProt,
  input logic              errPending,
  input logic [31:0]       errAddrQ
);
  a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !errMiss && !errAccProt && !errWrProt));

  a_r6_single_error: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errMiss, errAccProt, errWrProt}));

  a_r6_miss_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    errMiss |-> (!rspHit && rspTarget == 4'h0));

  a_r8_read_no_wrprot: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> !errWrProt);

  a_r9_hold_until_clear: assert property (@(posedge clk) disable iff (!rstN)
    (errPending && !(regWr && regAddr == REG_AW'(CLR_ADDR))) |=> (errPending && $stable(errAddrQ)));
endmodule

bind addr_window_guard awg_checker #(.REG_AW(REG_AW), .CLR_ADDR(ERRC_OFS)) i_chk (
  .clk, .rstN, .reqValid, .reqWrite, .regWr, .regAddr, .rspValid, .rspHit,
  .rspTarget, .errMiss, .errAccProt, .errWrProt, .errPending, .errAddrQ
);

// File: tb/test_addr_window_guard.sv
module test_addr_window_guard;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqChan = '0;
  logic        rspValid, rspHit, errMiss, errAccProt, errWrProt;
  logic [2:0]  rspWin;
  logic [3:0]  rspTarget;
  logic [7:0]  rspAttr;
  logic [31:0] rspRemap;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  addr_window_guard i_addr_window_guard (
    .clk, .rstN, .regWr, .regAddr, .regWrData, .regRdData,
    .reqValid, .reqAddr, .reqWrite, .reqChan,
    .rspValid, .rspHit, .rspWin, .rspTarget, .rspAttr, .rspRemap,
    .errMiss, .errAccProt, .errWrProt
  );

  // err field: {wrProt, accProt, miss}
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic [1:0]  ch;
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] remap;
    logic [2:0]  err;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000_0004, 1'b0, 2'd0, 1'b1, 3'd0, 4'h1, 8'h11, 32'hA0, 3'b000},
    '{32'h1000_FFFC, 1'b1, 2'd0, 1'b1, 3'd0, 4'h1, 8'h11, 32'hA0, 3'b000},
    '{32'h1001_0000, 1'b0, 2'd0, 1'b0, 3'd0, 4'h0, 8'h00, 32'h00, 3'b001},
    '{32'h200F_FFF0, 1'b0, 2'd0, 1'b1, 3'd1, 4'h2, 8'h22, 32'hB1, 3'b000},
    '{32'h2000_1234, 1'b1, 2'd0, 1'b1, 3'd1, 4'h2, 8'h22, 32'hB1, 3'b000},
    '{32'h3000_0000, 1'b0, 2'd0, 1'b0, 3'd0, 4'h0, 8'h00, 32'h00, 3'b001},
    '{32'h5000_0010, 1'b1, 2'd0, 1'b1, 3'd5, 4'h6, 8'h66, 32'h00, 3'b000},
    '{32'h1000_0000, 1'b0, 2'd1, 1'b1, 3'd0, 4'h1, 8'h11, 32'hA0, 3'b000},
    '{32'h1000_0000, 1'b1, 2'd1, 1'b1, 3'd0, 4'h1, 8'h11, 32'hA0, 3'b100},
    '{32'h2000_0000, 1'b0, 2'd1, 1'b1, 3'd1, 4'h2, 8'h22, 32'hB1, 3'b010},
    '{32'h5000_0000, 1'b0, 2'd1, 1'b1, 3'd5, 4'h6, 8'h66, 32'h00, 3'b010},
    '{32'h7000_0000, 1'b1, 2'd1, 1'b1, 3'd7, 4'h8, 8'h88, 32'h00, 3'b000},
    '{32'h7000_0000, 1'b0, 2'd2, 1'b1, 3'd7, 4'h8, 8'h88, 32'h00, 3'b010}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  // Drive at negedge, sample a quarter period after the capturing edge.
  task automatic request(input logic [31:0] a, input logic w, input logic [1:0] c);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqChan = c;
    @(posedge clk);
    #(PERIOD/4);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    // R10: reset state
    check(rspValid == 0 && errMiss == 0, "R10 reset outputs", {31'h0, rspValid}, 32'h0);
    for (int a = 0; a < 27; a++) begin
      regRead(6'(a), rd);
      check(rd == 32'h0, "R10 reset register", rd, 32'h0);
    end
    @(negedge clk); rstN = 1'b1;

    // R11: idle cycle gives nothing
    @(posedge clk); #(PERIOD/4);
    check(!rspValid && !errMiss, "R11 idle response", {31'h0, rspValid}, 32'h0);

    // R2: all windows disabled after reset -> miss
    request(32'h1000_0000, 1'b0, 2'd0);
    check(errMiss && !rspHit, "R2 reset miss", {31'h0, errMiss}, 32'h1);
    idle();
    regWrite(6'd26, 32'h0);

    // Program windows
    regWrite(6'd0, 32'h1000_1101); regWrite(6'd8,  32'h0000_0000);
    regWrite(6'd1, 32'h2000_2202); regWrite(6'd9,  32'h000F_0000);
    regWrite(6'd2, 32'h2000_3303); regWrite(6'd10, 32'h0000_0000);
    regWrite(6'd3, 32'h3000_4404); regWrite(6'd11, 32'h0000_0000);
    regWrite(6'd5, 32'h5000_6606); regWrite(6'd13, 32'h0000_0000);
    regWrite(6'd7, 32'h7000_8808); regWrite(6'd15, 32'h0000_0000);
    regWrite(6'd16, 32'hA0); regWrite(6'd17, 32'hB1);
    regWrite(6'd18, 32'hC2); regWrite(6'd19, 32'hD3);
    regWrite(6'd20, 32'h0000_00A7);
    regWrite(6'd21, 32'h0000_FFFF);
    regWrite(6'd22, 32'h0000_C831);

    // R10: readback format
    regRead(6'd1, rd);  check(rd == 32'h2000_2202, "R10 base readback", rd, 32'h2000_2202);
    regRead(6'd9, rd);  check(rd == 32'h000F_0000, "R10 size readback", rd, 32'h000F_0000);
    regRead(6'd20, rd); check(rd == 32'h0000_00A7, "R10 enable readback", rd, 32'hA7);
    regRead(6'd22, rd); check(rd == 32'h0000_C831, "R10 perm readback", rd, 32'hC831);

    // Vector table: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      request(VECS[i].addr, VECS[i].wr, VECS[i].ch);
      check(rspValid, "R4 valid", {31'h0, rspValid}, 32'h1);
      check(rspHit == VECS[i].hit && (!VECS[i].hit || rspWin == VECS[i].win),
            "R1/R2/R3 window", {28'h0, rspHit, rspWin}, {28'h0, VECS[i].hit, VECS[i].win});
      check(rspTarget == VECS[i].tgt && rspAttr == VECS[i].attr,
            "R4/R6 target attr", {20'h0, rspTarget, rspAttr}, {20'h0, VECS[i].tgt, VECS[i].attr});
      check(rspRemap == VECS[i].remap, "R5 remap", rspRemap, VECS[i].remap);
      check({errWrProt, errAccProt, errMiss} == VECS[i].err, "R6/R7/R8 error class",
            {29'h0, errWrProt, errAccProt, errMiss}, {29'h0, VECS[i].err});
      idle();
    end
    @(posedge clk); #(PERIOD/4);
    check(!rspValid, "R4 valid drops", {31'h0, rspValid}, 32'h0);

    // R9: first error (vector 2 miss) held despite later faults
    regRead(6'd25, rd); check(rd == 32'h1001_0000, "R9 held address", rd, 32'h1001_0000);
    regRead(6'd26, rd); check(rd == 32'h9, "R9 held cause", rd, 32'h9);
    regWrite(6'd26, 32'h0);
    regRead(6'd26, rd); check(rd == 32'h0, "R9 cleared cause", rd, 32'h0);
    regRead(6'd25, rd); check(rd == 32'h0, "R9 cleared address", rd, 32'h0);

    // R11: address presented without reqValid captures nothing
    @(negedge clk); reqAddr = 32'hDEAD_0000; reqWrite = 1'b1; reqChan = 2'd3;
    @(posedge clk); #(PERIOD/4);
    check(!errMiss && !rspValid, "R11 no response", {31'h0, errMiss}, 32'h0);
    regRead(6'd26, rd); check(rd == 32'h0, "R11 no capture", rd, 32'h0);

    // R9: new capture after clear, write-protect class
    request(32'h1000_0040, 1'b1, 2'd1);
    idle();
    regRead(6'd25, rd); check(rd == 32'h1000_0040, "R9 new address", rd, 32'h1000_0040);
    regRead(6'd26, rd); check(rd == 32'hC, "R9 new cause", rd, 32'hC);

    // R9: error in the same cycle as the clear is kept
    @(negedge clk);
    regWr = 1'b1; regAddr = 6'd26; regWrData = '0;
    reqValid = 1'b1; reqAddr = 32'h3000_0008; reqWrite = 1'b0; reqChan = 2'd0;
    @(negedge clk);
    regWr = 1'b0; reqValid = 1'b0;
    regRead(6'd25, rd); check(rd == 32'h3000_0008, "R9 clear-capture address", rd, 32'h3000_0008);
    regRead(6'd26, rd); check(rd == 32'h9, "R9 clear-capture cause", rd, 32'h9);

    // R2: enabling window 3 turns the previous miss into a hit (R7 code 3 for ch0)
    regWrite(6'd20, 32'h0000_00AF);
    request(32'h3000_0008, 1'b0, 2'd0);
    check(rspHit && rspWin == 3'd3 && rspTarget == 4'h4 && rspRemap == 32'hD3,
          "R2/R5 enabled window", {24'h0, rspTarget, 1'b0, rspWin}, 32'h43);
    idle();

    // R3: disable window 1 -> overlap now goes to window 2
    regWrite(6'd20, 32'h0000_00AD);
    request(32'h2000_1234, 1'b0, 2'd0);
    check(rspHit && rspWin == 3'd2 && rspTarget == 4'h3, "R3 next window",
          {24'h0, rspTarget, 1'b0, rspWin}, 32'h32);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule